// File: doc/BRIEF.md
# Inter-core doorbell mailbox

This block lets each of N cores (2 to 4) ring any core, itself included, with a short message. Every core has its own register bus. Through that bus it sees an outgoing command word and an outgoing 30-bit extension word for each target slot. It also sees, for each source slot, the command and extension word that has arrived from that source. A command written with its top bit set launches the message. The message then sits latched and pending until the target writes a one to that bit on its incoming side.

Each core has one level-sensitive interrupt line. The line is high while any incoming message whose source is enabled in the core's busy mask is still pending. It is also high while any completion flag the core holds is set and enabled in the core's done mask. A completion flag is raised for the sender when its target acknowledges. The sender clears it by writing a one to it. Bringing cores out of sleep is left to other logic.

Top module: `doorbell_mbox`

Register offsets on each core's bus (5-bit word address). For addresses below 16, the slot is address bits 3:2 and the kind is bits 1:0:
- kind 0: outgoing command to target slot
- kind 1: outgoing extension to target slot
- kind 2: incoming command from source slot
- kind 3: incoming extension from source slot

Above that:
- 16: busy mask
- 17: done mask
- 18: completion flags, one bit per target

## Requirements
- R1: After reset, or after reset is applied again later, every register reads zero, every mask is disabled and every interrupt line is low.
- R2: When core S writes its outgoing command for target T with bit 31 set and no message is pending, the next cycle meets two conditions. First, core T's incoming command from S reads bit 31 as one. Second, bits 30:0 read as written: a 7-bit type in bits 30:24 and a 24-bit header in bits 23:0. Core S sees the same word in its outgoing command register.
- R3: A command write with bit 31 clear launches nothing and stores nothing.
- R4: While a message from S to T is pending, writes by S to that command or extension register are ignored and the latched words do not change.
- R5: The extension register keeps bits 29:0 of the written word; bits 31:30 read as zero on both the sender and target side.
- R6: Writing one to bit 31 of an incoming command register clears the pending bit, which the sender sees as its busy bit clearing; writing zero there has no effect.
- R7: A core's interrupt is the level OR of its pending incoming slots enabled in its busy mask, including the slot for messages it sent to itself.
- R8: An acknowledge sets the sender's completion flag for that target (offset 18, bit T). That flag drives the sender's interrupt only when bit T of its done mask (offset 17) is set. Writing one to the flag clears it.
- R9: Busy and done masks keep only their low N bits, one per core; a pending message from a masked-off source raises no interrupt.
- R10: Offsets 19 to 31 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | N | Per-core write strobe |
| busAddr | input | 5*N | Per-core word address, core c at bits 5c+4:5c |
| busWdata | input | 32*N | Per-core write data, core c at bits 32c+31:32c |
| busRdata | output | 32*N | Per-core read data, combinational from that core's address |
| coreIrq | output | N | Per-core level interrupt |

## Verification
The assertions take several things for granted about the inputs. Each core issues at most one write per cycle. The address and data are stable across the clock edge at which the write strobe is sampled. Reset is asserted from time zero. The bench drives every bus on the falling edge, holds a write for exactly one cycle and samples reads a nanosecond after the address settles, so every access lands on a single rising edge. The busy-hold and acknowledge properties assume that a launch and an acknowledge for the same pair never coincide. That holds because one needs the pending bit clear and the other needs it set, and the stimulus exercises both orders on distinct pairs and on a core's own slot.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int MAXC    = 4;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;
  localparam int EXT_W   = 30;
  localparam int PAY_W   = DATA_W - 1;

  localparam logic [1:0] KIND_OUT_CMD = 2'd0;
  localparam logic [1:0] KIND_OUT_EXT = 2'd1;
  localparam logic [1:0] KIND_IN_CMD  = 2'd2;
  localparam logic [1:0] KIND_IN_EXT  = 2'd3;
  localparam logic [3:0] OFS_BUSY_MASK = 4'd0;
  localparam logic [3:0] OFS_DONE_MASK = 4'd1;
  localparam logic [3:0] OFS_DONE_FLAG = 4'd2;

  typedef struct packed {
    logic [MAXC-1:0][MAXC-1:0] launch;   // [src][tgt]
    logic [MAXC-1:0][MAXC-1:0] extWr;    // [src][tgt]
    logic [MAXC-1:0][MAXC-1:0] ack;      // [src][tgt]
    logic [MAXC-1:0]           busyMaskWr;
    logic [MAXC-1:0]           doneMaskWr;
    logic [MAXC-1:0]           doneClrWr;
  } dbStrobes_t;
endpackage

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import doorbell_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [MAXC-1:0]             weP,
  input  logic [MAXC-1:0][ADDR_W-1:0] addrP,
  input  logic [MAXC-1:0]             busyBitP,
  input  logic [MAXC-1:0][MAXC-1:0]   pendIn,
  output dbStrobes_t                  strb
);
  always_comb begin
    strb = '0;
    for (int c = 0; c < MAXC; c++) begin
      logic [1:0] slot;
      logic [1:0] kind;
      slot = addrP[c][3:2];
      kind = addrP[c][1:0];
      if (weP[c] && (c < N)) begin
        if (!addrP[c][4]) begin
          if (32'(slot) < N) begin
            unique case (kind)
              KIND_OUT_CMD: if (busyBitP[c] && !pendIn[c][slot]) strb.launch[c][slot] = 1'b1;
              KIND_OUT_EXT: if (!pendIn[c][slot]) strb.extWr[c][slot] = 1'b1;
              KIND_IN_CMD:  if (busyBitP[c] && pendIn[slot][c]) strb.ack[slot][c] = 1'b1;
              KIND_IN_EXT:  ;
            endcase
          end
        end else begin
          if (addrP[c][3:0] == OFS_BUSY_MASK) strb.busyMaskWr[c] = 1'b1;
          if (addrP[c][3:0] == OFS_DONE_MASK) strb.doneMaskWr[c] = 1'b1;
          if (addrP[c][3:0] == OFS_DONE_FLAG) strb.doneClrWr[c]  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/doorbell_dp.sv
module doorbell_dp
  import doorbell_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dbStrobes_t                  strb,
  input  logic [MAXC-1:0][ADDR_W-1:0] addrP,
  input  logic [MAXC-1:0][PAY_W-1:0]  wdataP,
  output logic [MAXC-1:0][MAXC-1:0]   pendOut,
  output logic [N-1:0][DATA_W-1:0]    rdata,
  output logic [N-1:0]                irq
);
  localparam logic [MAXC-1:0] VALID_MASK = MAXC'((1 << N) - 1);

  logic [MAXC-1:0][MAXC-1:0][PAY_W-1:0] cmdQ;
  logic [MAXC-1:0][MAXC-1:0][EXT_W-1:0] extQ;
  logic [MAXC-1:0][MAXC-1:0]            pendQ;
  logic [MAXC-1:0][MAXC-1:0]            doneQ;   // [sender][target]
  logic [MAXC-1:0][MAXC-1:0]            busyMaskQ;
  logic [MAXC-1:0][MAXC-1:0]            doneMaskQ;

  assign pendOut = pendQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ      <= '0;
      extQ      <= '0;
      pendQ     <= '0;
      doneQ     <= '0;
      busyMaskQ <= '0;
      doneMaskQ <= '0;
    end else begin
      for (int s = 0; s < MAXC; s++) begin
        if (strb.busyMaskWr[s]) busyMaskQ[s] <= wdataP[s][MAXC-1:0] & VALID_MASK;
        if (strb.doneMaskWr[s]) doneMaskQ[s] <= wdataP[s][MAXC-1:0] & VALID_MASK;
        for (int t = 0; t < MAXC; t++) begin
          if (strb.launch[s][t]) begin
            pendQ[s][t] <= 1'b1;
            cmdQ[s][t]  <= wdataP[s];
          end else if (strb.ack[s][t]) begin
            pendQ[s][t] <= 1'b0;
          end
          if (strb.extWr[s][t]) extQ[s][t] <= wdataP[s][EXT_W-1:0];
          if (strb.ack[s][t])
            doneQ[s][t] <= 1'b1;
          else if (strb.doneClrWr[s] && wdataP[s][t])
            doneQ[s][t] <= 1'b0;
        end
      end
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_core
    logic [MAXC-1:0] colPend;
    always_comb begin
      for (int s = 0; s < MAXC; s++) colPend[s] = pendQ[s][c];
    end
    assign irq[c] = (|(colPend & busyMaskQ[c])) | (|(doneQ[c] & doneMaskQ[c]));

    always_comb begin
      logic [1:0] slot;
      slot = addrP[c][3:2];
      rdata[c] = '0;
      if (!addrP[c][4]) begin
        if (32'(slot) < N) begin
          unique case (addrP[c][1:0])
            KIND_OUT_CMD: rdata[c] = {pendQ[c][slot], cmdQ[c][slot]};
            KIND_OUT_EXT: rdata[c] = {2'b00, extQ[c][slot]};
            KIND_IN_CMD:  rdata[c] = {pendQ[slot][c], cmdQ[slot][c]};
            KIND_IN_EXT:  rdata[c] = {2'b00, extQ[slot][c]};
          endcase
        end
      end else begin
        if (addrP[c][3:0] == OFS_BUSY_MASK) rdata[c] = DATA_W'(busyMaskQ[c]);
        if (addrP[c][3:0] == OFS_DONE_MASK) rdata[c] = DATA_W'(doneMaskQ[c]);
        if (addrP[c][3:0] == OFS_DONE_FLAG) rdata[c] = DATA_W'(doneQ[c]);
      end
    end

    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
      (busyMaskQ[c] == '0 && doneMaskQ[c] == '0) |-> !irq[c]);

    for (genvar t = 0; t < N; t++) begin : g_pair
      p_launch_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
        strb.launch[c][t] |=> pendQ[c][t]);
      p_no_launch_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
        pendQ[c][t] |-> !strb.launch[c][t] && !strb.extWr[c][t]);
      p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
        (pendQ[c][t] && !strb.ack[c][t]) |=>
          (pendQ[c][t] && $stable(cmdQ[c][t]) && $stable(extQ[c][t])));
      p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
        strb.ack[c][t] |=> !pendQ[c][t]);
      p_ack_done_r8: assert property (@(posedge clk) disable iff (!rstN)
        strb.ack[c][t] |=> doneQ[c][t]);
    end
  end
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import doorbell_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N-1:0]        busWe,
  input  logic [N*ADDR_W-1:0] busAddr,
  input  logic [N*DATA_W-1:0] busWdata,
  output logic [N*DATA_W-1:0] busRdata,
  output logic [N-1:0]        coreIrq
);
  logic [MAXC-1:0]             weP;
  logic [MAXC-1:0][ADDR_W-1:0] addrP;
  logic [MAXC-1:0][PAY_W-1:0]  wdataP;
  logic [MAXC-1:0]             busyBitP;
  logic [MAXC-1:0][MAXC-1:0]   pend;
  logic [N-1:0][DATA_W-1:0]    rdata;
  dbStrobes_t                  strb;

  for (genvar c = 0; c < MAXC; c++) begin : g_pad
    if (c < N) begin : g_live
      assign weP[c]      = busWe[c];
      assign addrP[c]    = busAddr[c*ADDR_W +: ADDR_W];
      assign wdataP[c]   = busWdata[c*DATA_W +: PAY_W];
      assign busyBitP[c] = busWdata[c*DATA_W + DATA_W - 1];
    end else begin : g_idle
      assign weP[c]      = 1'b0;
      assign addrP[c]    = '0;
      assign wdataP[c]   = '0;
      assign busyBitP[c] = 1'b0;
    end
  end

  assign busRdata = rdata;

  doorbell_ctrl #(.N(N)) ctrl_i (
    .weP(weP), .addrP(addrP), .busyBitP(busyBitP), .pendIn(pend), .strb(strb)
  );

  doorbell_dp #(.N(N)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addrP(addrP), .wdataP(wdataP),
    .pendOut(pend), .rdata(rdata), .irq(coreIrq)
  );
endmodule

// File: tb/doorbell_mbox_tb.sv
`timescale 1ns/1ps
module doorbell_mbox_tb_top;
  localparam int N = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [N-1:0]    busWe = '0;
  logic [N*5-1:0]  busAddr = '0;
  logic [N*32-1:0] busWdata = '0;
  logic [N*32-1:0] busRdata;
  logic [N-1:0]    coreIrq;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  doorbell_mbox #(.N(N)) dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .coreIrq(coreIrq)
  );

  typedef struct packed {
    logic [1:0]  wCore;
    logic [4:0]  wAddr;
    logic [31:0] wData;
    logic [1:0]  rCore;
    logic [4:0]  rAddr;
    logic [31:0] expData;
    logic [3:0]  expIrq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd16, 32'h0000_000F, 2'd0, 5'd16, 32'h0000_000F, 4'b0000, 4'd9},  // R9
    '{2'd1, 5'd16, 32'h0000_00FF, 2'd1, 5'd16, 32'h0000_000F, 4'b0000, 4'd9},  // R9 low N bits
    '{2'd0, 5'd5,  32'hFFFF_FFFF, 2'd1, 5'd3,  32'h3FFF_FFFF, 4'b0000, 4'd5},  // R5
    '{2'd0, 5'd4,  32'h8512_3456, 2'd1, 5'd2,  32'h8512_3456, 4'b0010, 4'd2},  // R2 R7
    '{2'd0, 5'd4,  32'h8000_0001, 2'd0, 5'd4,  32'h8512_3456, 4'b0010, 4'd4},  // R4 cmd
    '{2'd0, 5'd5,  32'h0000_0001, 2'd1, 5'd3,  32'h3FFF_FFFF, 4'b0010, 4'd4},  // R4 ext
    '{2'd1, 5'd2,  32'h0000_0000, 2'd1, 5'd2,  32'h8512_3456, 4'b0010, 4'd6},  // R6 zero
    '{2'd1, 5'd2,  32'h8000_0000, 2'd0, 5'd4,  32'h0512_3456, 4'b0000, 4'd6},  // R6 ack
    '{2'd0, 5'd20, 32'h0000_0000, 2'd0, 5'd18, 32'h0000_0002, 4'b0000, 4'd8},  // R8 flag
    '{2'd0, 5'd17, 32'h0000_0002, 2'd0, 5'd18, 32'h0000_0002, 4'b0001, 4'd8},  // R8 irq
    '{2'd0, 5'd18, 32'h0000_0002, 2'd0, 5'd18, 32'h0000_0000, 4'b0000, 4'd8},  // R8 w1c
    '{2'd2, 5'd8,  32'h8100_0007, 2'd2, 5'd10, 32'h8100_0007, 4'b0000, 4'd9},  // R9 masked
    '{2'd2, 5'd16, 32'h0000_0004, 2'd2, 5'd16, 32'h0000_0004, 4'b0100, 4'd7},  // R7 self
    '{2'd3, 5'd8,  32'h8000_00AA, 2'd2, 5'd14, 32'h8000_00AA, 4'b0100, 4'd7},  // R7 R9
    '{2'd2, 5'd10, 32'h8000_0000, 2'd2, 5'd8,  32'h0100_0007, 4'b0000, 4'd6},  // R6 self ack
    '{2'd0, 5'd0,  32'h7F00_0001, 2'd0, 5'd0,  32'h0000_0000, 4'b0000, 4'd3},  // R3
    '{2'd0, 5'd19, 32'hFFFF_FFFF, 2'd0, 5'd19, 32'h0000_0000, 4'b0000, 4'd10}, // R10
    '{2'd1, 5'd31, 32'hFFFF_FFFF, 2'd1, 5'd31, 32'h0000_0000, 4'b0000, 4'd10}  // R10
  };

  task automatic doWr(input int core, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe[core] = 1'b1;
    busAddr[core*5 +: 5] = a;
    busWdata[core*32 +: 32] = d;
    @(negedge clk);
    busWe = '0;
  endtask

  task automatic chk(input int core, input logic [4:0] a, input logic [31:0] expD,
                     input logic [3:0] expI, input string req);
    logic [31:0] got;
    busAddr[core*5 +: 5] = a;
    #1;
    got = busRdata[core*32 +: 32];
    nTests++;
    if (got !== expD) begin
      nFail++;
      $display("FAIL %s core%0d addr %0d: data got %h expected %h", req, core, a, got, expD);
    end
    nTests++;
    if (coreIrq !== expI) begin
      nFail++;
      $display("FAIL %s irq got %b expected %b", req, coreIrq, expI);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(0, 5'd4,  32'h0, 4'b0000, "R1");
    chk(3, 5'd16, 32'h0, 4'b0000, "R1");
    chk(1, 5'd18, 32'h0, 4'b0000, "R1");

    for (int i = 0; i < NV; i++) begin
      doWr(int'(VECS[i].wCore), VECS[i].wAddr, VECS[i].wData);
      chk(int'(VECS[i].rCore), VECS[i].rAddr, VECS[i].expData, VECS[i].expIrq,
          $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R5 corner: sender side also hides bits 31:30 of the extension
    chk(0, 5'd5, 32'h3FFF_FFFF, 4'b0000, "R5 sender view");
    // R2: a further launch is accepted once the slot is free again
    doWr(0, 5'd4, 32'hFE00_0001);
    chk(1, 5'd2, 32'hFE00_0001, 4'b0010, "R2 relaunch");

    // R1: reset applied mid-run clears pending messages and masks
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    chk(2, 5'd14, 32'h0, 4'b0000, "R1 mid-run pending");
    chk(1, 5'd2,  32'h0, 4'b0000, "R1 mid-run incoming");
    chk(0, 5'd16, 32'h0, 4'b0000, "R1 mid-run mask");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule